// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a register-programmed watchdog for a small processor system. Software sets a reload value, a clock divider and the set of outputs to fire, then enables the timer. A countdown runs from the reload value, stepping once per divided clock tick. Software must restart it before it reaches zero. If the count reaches zero while the timer is enabled, the block pulses any chosen combination of three outputs: a system reset request, an interrupt and an external alarm line. Each output stays high for its own programmed number of clock cycles.

Every register write must carry a fixed key byte in its top eight bits. A write without the key changes nothing. A debug input stops the divider and the countdown while a processor is halted. After an expiry the timer reloads and keeps running. A sticky flag records that the expiry happened, and it stays set until software clears it.

Top module: `wdt_periph`

## Requirements
- R1: After power-on reset (rst_n low): CTRL reads 0, TIMEOUT reads 0x0000FF, HOLD reads 0x040404, the STATUS flag reads 0, and all three outputs are low.
- R2: A write (bus_sel=1, bus_we=1) takes effect only when bus_wdata[31:24] equals 0xA5. With any other value in that byte, no register, counter or flag changes.
- R3: Word addresses are 0 CTRL, 1 TIMEOUT, 2 HOLD and 3 STATUS, and they follow this layout:
  - CTRL: [0] enable, [1] select reset, [2] select interrupt, [3] select external, [7:4] prescale exponent.
  - TIMEOUT: [15:0] reload value.
  - HOLD: [7:0] reset hold, [15:8] interrupt hold, [23:16] external hold.
  - STATUS read: [0] expiry flag, [23:8] current count.

  Reads are combinational and return 0 in bits [31:24]. Addresses 4 to 7 read 0, and bus_rdata is 0 while bus_sel is low.
- R4: With reload value T and prescale exponent P (P set by an earlier write), the countdown steps once every 2^P clocks. An expiry loads the hold counters on the (T+1)*2^P-th rising edge after the write that enables the timer or restarts it. The selected outputs are first high after that edge, and the count is reloaded to T at that same edge.
- R5: A keyed write to STATUS with bit 0 set reloads both the count and the divider. Restarts made more often than the timeout period prevent any expiry.
- R6: Only the outputs whose select bit is set assert on expiry. While enable is 0 the count is held at TIMEOUT and no expiry occurs.
- R7: Each asserted output stays high for exactly its HOLD field's number of cycles. A field of 0 means the output never asserts. Several outputs assert together, and each one ends independently of the others.
- R8: While dbg_halt is high, the divider and the count hold their values and the expiry is delayed by the number of halted edges. Hold counters that are already running keep counting.
- R9: An expiry sets the STATUS flag. The timer keeps expiring every (T+1)*2^P clocks. The flag is cleared only by a keyed write to STATUS with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Power-on reset, active low |
| dbg_halt | input | 1 | Freeze divider and countdown |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data, key in [31:24] |
| bus_rdata | output | 32 | Read data |
| rst_out | output | 1 | System reset request |
| irq_out | output | 1 | Interrupt |
| ext_out | output | 1 | External alarm line |

## Verification
The main function is tried with four patterns, and each one tells a different fault apart:
- An undivided clock with a single selected output catches off-by-one errors in the countdown.
- A divided clock shows whether the divider is multiplied in, and whether the divider is reloaded at enable.
- A mix of selections with unequal holds, including a hold of zero, separates the three hold channels from one another.
- Regular restarts followed by a missed restart show whether a restart reloads the count.

Halting the count before an expiry, and separately during a hold, shows whether the freeze reaches only the countdown. Unkeyed writes followed by read-back show that the key gate blocks every register and the flag clear.

// File: rtl/wdt_periph.sv
module wdt_periph #(
  parameter int          ADDR_W      = 3,
  parameter int          CNT_W       = 16,
  parameter int          HOLD_W      = 8,
  parameter int          PS_W        = 4,
  parameter logic [7:0]  KEY         = 8'hA5,
  parameter logic [15:0] TIMEOUT_RST = 16'h00FF,
  parameter logic [7:0]  HOLD_RST    = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_out,
  output logic              irq_out,
  output logic              ext_out
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int NOUT  = 3;

  logic                          en_q;
  logic [NOUT-1:0]               sel_q;
  logic [PS_W-1:0]               ps_q;
  logic [CNT_W-1:0]              tmo_q;
  logic [NOUT-1:0][HOLD_W-1:0]   hcfg_q;
  logic [NOUT-1:0][HOLD_W-1:0]   hcnt_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [DIV_W-1:0]              pcnt_q;
  logic                          flag_q;

  logic wr_ok, wr_ctrl, wr_tmo, wr_hold, wr_stat, kick, clr, run, tick, expire;
  logic [DIV_W-1:0] div_load;

  assign wr_ok   = bus_sel & bus_we & (bus_wdata[31:24] == KEY);
  assign wr_ctrl = wr_ok & (bus_addr == ADDR_W'(0));
  assign wr_tmo  = wr_ok & (bus_addr == ADDR_W'(1));
  assign wr_hold = wr_ok & (bus_addr == ADDR_W'(2));
  assign wr_stat = wr_ok & (bus_addr == ADDR_W'(3));
  assign kick    = wr_stat & bus_wdata[0];
  assign clr     = wr_stat & bus_wdata[1];

  assign div_load = (DIV_W'(1) << ps_q) - DIV_W'(1);
  assign run      = en_q & ~dbg_halt;
  assign tick     = run & (pcnt_q == '0);
  assign expire   = tick & (cnt_q == '0) & ~kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      ps_q   <= '0;
      tmo_q  <= CNT_W'(TIMEOUT_RST);
      hcfg_q <= {NOUT{HOLD_W'(HOLD_RST)}};
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[0];
        sel_q <= bus_wdata[NOUT:1];
        ps_q  <= bus_wdata[NOUT+PS_W:NOUT+1];
      end
      if (wr_tmo)
        tmo_q <= bus_wdata[CNT_W-1:0];
      if (wr_hold)
        for (int i = 0; i < NOUT; i++)
          hcfg_q[i] <= bus_wdata[i*8 +: HOLD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= CNT_W'(TIMEOUT_RST);
    end else if (!en_q || kick) begin
      pcnt_q <= div_load;
      cnt_q  <= tmo_q;
    end else if (run) begin
      pcnt_q <= (pcnt_q == '0) ? div_load : pcnt_q - DIV_W'(1);
      if (tick)
        cnt_q <= (cnt_q == '0) ? tmo_q : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (clr)    flag_q <= 1'b0;
  end

  logic [NOUT-1:0] hold_on;

  for (genvar g = 0; g < NOUT; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    hcnt_q[g] <= '0;
      else if (expire && sel_q[g])   hcnt_q[g] <= hcfg_q[g];
      else if (hcnt_q[g] != '0)      hcnt_q[g] <= hcnt_q[g] - HOLD_W'(1);
    end
    assign hold_on[g] = (hcnt_q[g] != '0);

    // R7: a running hold counter steps down by one each edge
    p_hold_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt_q[g] != '0 && !(expire && sel_q[g])) |=> (hcnt_q[g] == $past(hcnt_q[g]) - HOLD_W'(1)));

    // R6: an output only rises if it was selected
    p_rise_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_on[g]) |-> $past(sel_q[g]));
  end

  assign rst_out = hold_on[0];
  assign irq_out = hold_on[1];
  assign ext_out = hold_on[2];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        ADDR_W'(0): bus_rdata = 32'({ps_q, sel_q, en_q});
        ADDR_W'(1): bus_rdata = 32'(tmo_q);
        ADDR_W'(2): bus_rdata = {8'h00, 8'(hcfg_q[2]), 8'(hcfg_q[1]), 8'(hcfg_q[0])};
        ADDR_W'(3): bus_rdata = {8'h00, 16'(cnt_q), 7'h00, flag_q};
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R2: an unkeyed write leaves every configuration register untouched
  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_wdata[31:24] != KEY) |=>
      ($stable(en_q) && $stable(sel_q) && $stable(ps_q) && $stable(tmo_q) && $stable(hcfg_q)));

  // R8: halted count and divider do not move
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && en_q && !kick) |=> ($stable(cnt_q) && $stable(pcnt_q)));

  // R4: an expiry reloads the countdown from TIMEOUT
  p_expiry_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(tmo_q)));

  // R9: the flag stays set until a keyed clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: tb/wdt_periph_tb.sv
module wdt_periph_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] K = 32'hA500_0000;

  logic clk = 1'b0, rst_n = 1'b0, dbg_halt = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rst_out, irq_out, ext_out;

  int n_chk = 0, n_bad = 0;
  int first[3], cnt[3];
  logic [31:0] rv;

  wdt_periph u_dut (.clk, .rst_n, .dbg_halt, .bus_sel, .bus_we, .bus_addr,
                    .bus_wdata, .bus_rdata, .rst_out, .irq_out, .ext_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // observe ncyc edges; dbg_halt high for edges a+1..b
  task automatic window(input int ncyc, input int a, input int b);
    for (int i = 0; i < 3; i++) begin first[i] = -1; cnt[i] = 0; end
    for (int n = 1; n <= ncyc; n++) begin
      logic [2:0] o;
      @(posedge clk);
      @(negedge clk);
      o = {ext_out, irq_out, rst_out};
      for (int i = 0; i < 3; i++) if (o[i]) begin
        cnt[i]++;
        if (first[i] < 0) first[i] = n;
      end
      dbg_halt = (n >= a && n < b);
    end
    dbg_halt = 1'b0;
  endtask

  task automatic setup(input logic [15:0] t, input logic [23:0] h, input logic [3:0] ps);
    wr(3'd0, K);
    wr(3'd1, K | 32'(t));
    wr(3'd2, K | 32'(h));
    wr(3'd0, K | 32'({ps, 3'b000, 1'b0}));
    repeat (8) @(negedge clk);
    wr(3'd3, K | 32'h2);
  endtask

  task automatic t_reset;
    chk("R3 idle rdata", bus_rdata, 32'h0);
    chk("R1 outputs", 32'({rst_out, irq_out, ext_out}), 32'h0);
    rd(3'd0, rv); chk("R1 CTRL", rv, 32'h0);
    rd(3'd1, rv); chk("R1 TIMEOUT", rv, 32'h0000_00FF);
    rd(3'd2, rv); chk("R1 HOLD", rv, 32'h0004_0404);
    rd(3'd3, rv); chk("R1 STATUS flag", rv & 32'h1, 32'h0);
    rd(3'd5, rv); chk("R3 unmapped", rv, 32'h0);
  endtask

  task automatic t_key;
    wr(3'd0, 32'h0000_000F);
    rd(3'd0, rv); chk("R2 unkeyed CTRL", rv, 32'h0);
    wr(3'd1, 32'h5A00_1234);
    rd(3'd1, rv); chk("R2 unkeyed TIMEOUT", rv, 32'h0000_00FF);
    wr(3'd1, K | 32'h1234);
    rd(3'd1, rv); chk("R3 keyed TIMEOUT read", rv, 32'h0000_1234);
    wr(3'd2, K | 32'h030201);
    rd(3'd2, rv); chk("R3 HOLD layout", rv, 32'h0003_0201);
  endtask

  task automatic t_basic;
    setup(16'd20, 24'h050203, 4'd0);
    wr(3'd0, K | 32'h5);
    window(30, 99, 99);
    chk("R4 irq first edge", 32'(first[1]), 32'd21);
    chk("R7 irq hold", 32'(cnt[1]), 32'd2);
    chk("R6 rst unselected", 32'(cnt[0]), 32'd0);
    chk("R6 ext unselected", 32'(cnt[2]), 32'd0);
  endtask

  task automatic t_prescale;
    setup(16'd3, 24'h050203, 4'd2);
    wr(3'd0, K | 32'h23);
    window(20, 99, 99);
    chk("R4 prescaled first edge", 32'(first[0]), 32'd16);
    chk("R7 rst hold", 32'(cnt[0]), 32'd3);
  endtask

  task automatic t_multi;
    setup(16'd20, 24'h050003, 4'd0);
    wr(3'd0, K | 32'hF);
    window(30, 99, 99);
    chk("R7 rst first", 32'(first[0]), 32'd21);
    chk("R7 ext first", 32'(first[2]), 32'd21);
    chk("R7 rst hold 3", 32'(cnt[0]), 32'd3);
    chk("R7 ext hold 5", 32'(cnt[2]), 32'd5);
    chk("R7 irq hold 0", 32'(cnt[1]), 32'd0);
  endtask

  task automatic t_restart;
    int tot;
    setup(16'd10, 24'h010101, 4'd0);
    wr(3'd0, K | 32'h3);
    tot = 0;
    for (int k = 0; k < 5; k++) begin
      window(7, 99, 99);
      tot += cnt[0];
      wr(3'd3, K | 32'h1);
    end
    chk("R5 no expiry with restarts", 32'(tot), 32'd0);
    window(12, 99, 99);
    chk("R5 expiry after missed restart", 32'(first[0]), 32'd11);
  endtask

  task automatic t_disable;
    setup(16'd4, 24'h010101, 4'd0);
    window(40, 99, 99);
    chk("R6 disabled no output", 32'(cnt[0] + cnt[1] + cnt[2]), 32'd0);
    rd(3'd3, rv);
    chk("R6 count held at TIMEOUT", rv, 32'h0000_0400);
  endtask

  task automatic t_debug;
    setup(16'd10, 24'h050101, 4'd0);
    wr(3'd0, K | 32'h9);
    window(25, 2, 6);
    chk("R8 frozen count delays expiry", 32'(first[2]), 32'd15);
    setup(16'd10, 24'h050101, 4'd0);
    wr(3'd0, K | 32'h9);
    window(20, 11, 14);
    chk("R8 hold runs during halt", 32'(cnt[2]), 32'd5);
  endtask

  task automatic t_sticky;
    setup(16'd5, 24'h010101, 4'd0);
    wr(3'd0, K | 32'h3);
    window(20, 99, 99);
    chk("R9 first expiry", 32'(first[0]), 32'd6);
    chk("R9 repeated expiries", 32'(cnt[0]), 32'd3);
    wr(3'd0, K);
    rd(3'd3, rv); chk("R9 flag set", rv & 32'h1, 32'h1);
    wr(3'd3, 32'h0000_0002);
    rd(3'd3, rv); chk("R2 unkeyed clear ignored", rv & 32'h1, 32'h1);
    wr(3'd3, K | 32'h2);
    rd(3'd3, rv); chk("R9 keyed clear", rv & 32'h1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_key();
    t_basic();
    t_prescale();
    t_multi();
    t_restart();
    t_disable();
    t_debug();
    t_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule